// File: doc/BRIEF.md
# Single-Entry Posted Write Buffer

This block sits between a core-side request port and a slower downstream peripheral port. It holds at most one write. A write is taken into that slot at once, so the core can move on while the slot drains to the peripheral in the background. Any read that arrives while a write is still held is not accepted until that write has finished downstream. A plain read of any address therefore works as a completion fence. Accesses leave the block in exactly the order they were issued.

A read is sent downstream only when nothing else is in flight. Its data comes back to the core after the downstream transfer completes, and no other request is accepted while the read is outstanding. A drain handshake stands in for a barrier: the drain-done output is high only when no write is held and no read is pending. The downstream port uses a valid/ready handshake, so a peripheral bridge can add any number of wait states.

Top module: `pwb_buffer`

## Requirements
- R1: Only one write is held at a time. A write presented while a write is held, and while the downstream port does not signal ready, sees `c_ready` low.
- R2: When no write is held and no read is pending, a write (`c_write`=1) is accepted in the same cycle it is presented, before any downstream transfer has completed.
- R3: A read (`c_write`=0) is not accepted while a write is held or a read is pending. A read that follows a write is accepted only in a cycle after that write's downstream handshake.
- R4: Downstream transfers appear in issue order. Once `p_valid` is high, it stays high with `p_write` and `p_addr` unchanged until `p_ready` is seen.
- R5: `drain_done` is high exactly when `drain_req` is high, no write is held and no read is pending.
- R6: A write stalled behind a held write is accepted in the same cycle that the held write completes its downstream handshake.
- R7: `c_rvalid` is high for one cycle, in the cycle after the downstream read handshake. In that cycle `c_rdata` carries the `p_rdata` value sampled at that handshake.
- R8: `busy` is high whenever a write is held or a read is pending, and low otherwise.
- R9: After reset, `p_valid`, `c_rvalid` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c_valid | input | 1 | Core request present |
| c_write | input | 1 | 1 = write, 0 = read |
| c_addr | input | AW | Request address |
| c_wdata | input | DW | Write data |
| c_ready | output | 1 | Request accepted this cycle when c_valid is high |
| c_rvalid | output | 1 | Read data valid pulse |
| c_rdata | output | DW | Read data |
| p_valid | output | 1 | Downstream transfer request |
| p_write | output | 1 | Downstream transfer is a write |
| p_addr | output | AW | Downstream address |
| p_wdata | output | DW | Downstream write data |
| p_ready | input | 1 | Downstream transfer completes this cycle |
| p_rdata | input | DW | Downstream read data |
| drain_req | input | 1 | Barrier request |
| drain_done | output | 1 | Barrier satisfied |
| busy | output | 1 | Write held or read pending |

## Verification
The hardest case to reach is a stalled second write that must land in the exact cycle its predecessor finishes downstream. The other case is a read that must not slip in during the cycle a held write retires. The bench reaches both by issuing two writes back to back, and a write followed directly by a read of the same address, against a peripheral model that inserts several wait states. It records the cycle of each downstream write handshake and compares it with the cycle in which the next request was accepted.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } pwb_op_e;
endpackage

// File: rtl/pwb_slot.sv
module pwb_slot #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    input  logic          done,
    output logic          vld,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data
);
    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (done) begin
            st_d.vld = 1'b0;
        end
        if (load) begin
            st_d.vld  = 1'b1;
            st_d.addr = addr_in;
            st_d.data = data_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld  = st_q.vld;
    assign addr = st_q.addr;
    assign data = st_q.data;
endmodule

// File: rtl/pwb_rdtrk.sv
module pwb_rdtrk #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic [AW-1:0] addr_in,
    input  logic          done,
    input  logic [DW-1:0] rdata_in,
    output logic          pend,
    output logic [AW-1:0] addr,
    output logic          rvalid,
    output logic [DW-1:0] rdata
);
    typedef struct packed {
        logic          pend;
        logic [AW-1:0] addr;
        logic          rvalid;
        logic [DW-1:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d        = rd_q;
        rd_d.rvalid = 1'b0;
        if (done) begin
            rd_d.pend   = 1'b0;
            rd_d.rvalid = 1'b1;
            rd_d.rdata  = rdata_in;
        end
        if (issue) begin
            rd_d.pend = 1'b1;
            rd_d.addr = addr_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign pend   = rd_q.pend;
    assign addr   = rd_q.addr;
    assign rvalid = rd_q.rvalid;
    assign rdata  = rd_q.rdata;
endmodule

// File: rtl/pwb_ctl.sv
module pwb_ctl
    import pwb_pkg::*;
(
    input  logic    c_valid,
    input  logic    c_write,
    input  logic    slot_vld,
    input  logic    rd_pend,
    input  logic    p_ready,
    output logic    c_ready,
    output logic    wr_load,
    output logic    rd_issue,
    output logic    wr_done,
    output logic    rd_done,
    output pwb_op_e op
);
    logic wr_ok;
    logic rd_ok;

    always_comb begin
        if (slot_vld) begin
            op = OP_WRITE;
        end else if (rd_pend) begin
            op = OP_READ;
        end else begin
            op = OP_NONE;
        end
        wr_done  = (op == OP_WRITE) && p_ready;
        rd_done  = (op == OP_READ) && p_ready;
        wr_ok    = !rd_pend && (!slot_vld || wr_done);
        rd_ok    = !slot_vld && !rd_pend;
        c_ready  = c_write ? wr_ok : rd_ok;
        wr_load  = c_valid && c_write && wr_ok;
        rd_issue = c_valid && !c_write && rd_ok;
    end
endmodule

// File: rtl/pwb_buffer.sv
module pwb_buffer
    import pwb_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          c_valid,
    input  logic          c_write,
    input  logic [AW-1:0] c_addr,
    input  logic [DW-1:0] c_wdata,
    output logic          c_ready,
    output logic          c_rvalid,
    output logic [DW-1:0] c_rdata,
    output logic          p_valid,
    output logic          p_write,
    output logic [AW-1:0] p_addr,
    output logic [DW-1:0] p_wdata,
    input  logic          p_ready,
    input  logic [DW-1:0] p_rdata,
    input  logic          drain_req,
    output logic          drain_done,
    output logic          busy
);
    logic          slot_vld;
    logic [AW-1:0] slot_addr;
    logic [DW-1:0] slot_data;
    logic          rd_pend;
    logic [AW-1:0] rd_addr;
    logic          wr_load;
    logic          rd_issue;
    logic          wr_done;
    logic          rd_done;
    pwb_op_e       op;

    pwb_ctl u_ctl (
        .c_valid  (c_valid),
        .c_write  (c_write),
        .slot_vld (slot_vld),
        .rd_pend  (rd_pend),
        .p_ready  (p_ready),
        .c_ready  (c_ready),
        .wr_load  (wr_load),
        .rd_issue (rd_issue),
        .wr_done  (wr_done),
        .rd_done  (rd_done),
        .op       (op)
    );

    pwb_slot #(.AW(AW), .DW(DW)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (wr_load),
        .addr_in (c_addr),
        .data_in (c_wdata),
        .done    (wr_done),
        .vld     (slot_vld),
        .addr    (slot_addr),
        .data    (slot_data)
    );

    pwb_rdtrk #(.AW(AW), .DW(DW)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (rd_issue),
        .addr_in  (c_addr),
        .done     (rd_done),
        .rdata_in (p_rdata),
        .pend     (rd_pend),
        .addr     (rd_addr),
        .rvalid   (c_rvalid),
        .rdata    (c_rdata)
    );

    assign p_valid    = (op != OP_NONE);
    assign p_write    = (op == OP_WRITE);
    assign p_addr     = (op == OP_WRITE) ? slot_addr : rd_addr;
    assign p_wdata    = slot_data;
    assign busy       = slot_vld || rd_pend;
    assign drain_done = drain_req && !busy;
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          c_valid,
    input logic          c_write,
    input logic          c_ready,
    input logic          c_rvalid,
    input logic [DW-1:0] c_rdata,
    input logic          p_valid,
    input logic          p_write,
    input logic [AW-1:0] p_addr,
    input logic          p_ready,
    input logic [DW-1:0] p_rdata,
    input logic          drain_req,
    input logic          drain_done,
    input logic          busy
);
    AST_WR_TAKEN_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (c_valid && c_write && !busy) |-> c_ready); // R2

    AST_RD_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (c_valid && !c_write && busy) |-> !c_ready); // R3

    AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (c_valid && c_write && c_ready && p_valid) |-> (p_write && p_ready)); // R1

    AST_DS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (p_valid && !p_ready) |=> (p_valid && $stable(p_write) && $stable(p_addr))); // R4

    AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        drain_done |-> (drain_req && !busy && !p_valid)); // R5

    AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (p_valid && p_ready && !p_write) |=> (c_rvalid && c_rdata == $past(p_rdata))); // R7

    AST_BUSY_COVERS_DS: assert property (@(posedge clk) disable iff (!rst_n)
        p_valid |-> busy); // R8
endmodule

bind pwb_buffer pwb_checker #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_pwb_buffer.sv
module sim_pwb_buffer;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int WAIT_ST = 3;

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          c_valid = 1'b0;
    logic          c_write = 1'b0;
    logic [AW-1:0] c_addr = '0;
    logic [DW-1:0] c_wdata = '0;
    logic          c_ready;
    logic          c_rvalid;
    logic [DW-1:0] c_rdata;
    logic          p_valid;
    logic          p_write;
    logic [AW-1:0] p_addr;
    logic [DW-1:0] p_wdata;
    logic          p_ready;
    logic [DW-1:0] p_rdata;
    logic          drain_req = 1'b0;
    logic          drain_done;
    logic          busy;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int last_wr_cyc = -1;
    bit finished = 1'b0;
    item_t exp_q[$];
    logic [DW-1:0] rd_q[$];
    logic [DW-1:0] shadow [16];
    logic [DW-1:0] mem [16];
    logic [3:0] wcnt;

    pwb_buffer #(.AW(AW), .DW(DW)) u0 (.*);

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // peripheral model with a fixed number of wait states
    assign p_ready = p_valid && (wcnt == 4'(WAIT_ST));
    assign p_rdata = mem[p_addr[3:0]];
    always @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= '0;
            for (int i = 0; i < 16; i++) mem[i] <= '0;
        end else begin
            wcnt <= (p_valid && !p_ready) ? wcnt + 4'd1 : 4'd0;
            if (p_valid && p_ready && p_write) mem[p_addr[3:0]] <= p_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output int stalls, output int acc);
        c_valid = 1'b1; c_write = wr; c_addr = a; c_wdata = d;
        stalls = 0;
        #1;
        while (!c_ready) begin
            @(negedge clk); #1;
            stalls++;
        end
        acc = cyc;
        exp_q.push_back('{wr: wr, a: a, d: (wr ? d : '0)});
        if (wr) shadow[a[3:0]] = d;
        else rd_q.push_back(shadow[a[3:0]]);
        @(negedge clk);
        c_valid = 1'b0;
    endtask

    task automatic settle();
        while (exp_q.size() != 0 || rd_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: downstream order and read data against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_valid && p_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4", "unexpected downstream transfer", {31'b0, p_write}, 32'hx);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    chk(p_write == e.wr, "R4", "downstream kind", {31'b0, p_write}, {31'b0, e.wr});
                    chk(p_addr == e.a, "R4", "downstream addr", {24'b0, p_addr}, {24'b0, e.a});
                    if (e.wr) chk(p_wdata == e.d, "R4", "downstream wdata", p_wdata, e.d);
                end
                if (p_write) last_wr_cyc = cyc;
            end
            if (c_rvalid) begin
                if (rd_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected read data", c_rdata, 32'hx);
                end else begin
                    logic [DW-1:0] er;
                    er = rd_q.pop_front();
                    chk(c_rdata == er, "R7", "read data", c_rdata, er);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R4 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        int st, ac, st2, ac2;
        for (int i = 0; i < 16; i++) shadow[i] = '0;
        drain_req = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(busy == 1'b0, "R8", "busy after reset", {31'b0, busy}, 0);
        chk(p_valid == 1'b0, "R9", "p_valid after reset", {31'b0, p_valid}, 0);
        chk(c_rvalid == 1'b0, "R9", "c_rvalid after reset", {31'b0, c_rvalid}, 0);
        chk(drain_done == 1'b1, "R5", "drain when empty", {31'b0, drain_done}, 1);
        drain_req = 1'b0;
        @(negedge clk);

        // write then read of the same address
        access(1'b1, 8'h05, 32'hA5A5_0001, st, ac);
        chk(st == 0, "R2", "write stall cycles when idle", st, 0);
        chk(busy == 1'b1, "R8", "busy with held write", {31'b0, busy}, 1);
        drain_req = 1'b1; #1;
        chk(drain_done == 1'b0, "R5", "drain while write held", {31'b0, drain_done}, 0);
        drain_req = 1'b0;
        access(1'b0, 8'h05, '0, st2, ac2);
        chk(ac2 > last_wr_cyc && last_wr_cyc >= ac, "R3", "read accept after write done",
            ac2, last_wr_cyc + 1);
        chk(st2 >= WAIT_ST, "R3", "read stall cycles", st2, WAIT_ST);
        while (!c_rvalid) @(negedge clk);
        @(negedge clk);
        chk(c_rvalid == 1'b0, "R7", "rvalid single pulse", {31'b0, c_rvalid}, 0);
        settle();
        chk(busy == 1'b0, "R8", "busy after read done", {31'b0, busy}, 0);

        // two writes back to back
        access(1'b1, 8'h06, 32'h1111_0006, st, ac);
        access(1'b1, 8'h07, 32'h2222_0007, st2, ac2);
        chk(st2 > 0, "R1", "second write stalled", st2, 1);
        chk(ac2 == last_wr_cyc, "R6", "second write accept cycle", ac2, last_wr_cyc);
        access(1'b0, 8'h07, '0, st, ac);
        access(1'b0, 8'h06, '0, st, ac);
        settle();

        // drain handshake behind a held write
        access(1'b1, 8'h09, 32'h0BAD_F00D, st, ac);
        drain_req = 1'b1; #1;
        while (!drain_done) begin @(negedge clk); #1; end
        chk(busy == 1'b0, "R5", "busy when drain done", {31'b0, busy}, 0);
        chk(exp_q.size() == 0, "R5", "pending items at drain done", exp_q.size(), 0);
        @(negedge clk);
        drain_req = 1'b0;

        // mixed traffic in program order
        for (int i = 0; i < 6; i++) begin
            access(1'b1, 8'(i), 32'hC0DE_0000 + i, st, ac);
            access(1'b0, 8'((i + 15) % 16), '0, st, ac);
            access(1'b1, 8'(i + 8), 32'hFACE_0000 + i, st, ac);
        end
        access(1'b0, 8'h03, '0, st, ac);
        access(1'b0, 8'h0A, '0, st, ac);
        settle();
        chk(p_valid == 1'b0, "R4", "downstream idle at end", {31'b0, p_valid}, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule